// File: doc/BRIEF.md
# USB device suspend and resume controller

This block watches the decoded upstream line state of a USB device and decides when the device goes into suspend and when it comes out. Time is measured in ticks of an external one-microsecond strobe. At full speed, a long stretch of J puts the device to sleep. At high speed, a long stretch of SE0 is ambiguous: it can be a bus reset or a suspend. The block therefore first falls back to full-speed terminations, waits a fixed delay, and then samples the line. J means suspend. SE0 means a reset, and the block raises a one-cycle handoff to the reset handshake logic.

While suspended, the block keeps a flag recording that the link was at high speed. A host resume ends with a K-to-SE0 edge. After a short end-of-resume window, the block restores the high-speed termination without a reset and restarts its idle timer. A remote wakeup may be requested. It is honoured only when enabled and only after a long enough idle period. A request that arrives too early is held until the idle period is long enough. The K drive lasts a fixed number of ticks and is then released, so the line floats rather than being driven to J.

Line state encoding used throughout: `2'b00` = SE0, `2'b01` = J, `2'b10` = K, `2'b11` = SE1 (treated as non-idle).

Top module: `usb_susp_ctrl`

## Requirements
- R1: In full-speed mode, `suspended` rises on the tick that makes the count of consecutive idle (J) ticks exceed IDLE_SUSP_US (3000). Any non-J cycle restarts the count.
- R2: With `hs_mode` or the remembered high-speed bit set, SE0 counts as idle. On the REVERT_US-th (3060) consecutive idle tick, `hs_term_en` drops and `fs_pullup_en` rises. Before that tick, the termination stays at high speed.
- R3: SAMPLE_US (500) ticks after reversion, the line is sampled. J enters suspend with `hs_remembered` set. SE0 pulses `reset_handoff` for one cycle, clears `hs_remembered` and stays out of suspend.
- R4: `hs_remembered` holds across suspend. When resume completes, `hs_term_en` returns high even if `hs_mode` is low, with no reset handoff.
- R5: A resume ends when SE0 follows a K and holds for EOR_US (2) ticks. Then `suspended` falls and the idle count restarts from zero at that point.
- R6: `drive_k` rises only while suspended with `rwake_en` high and at least RWAKE_IDLE_US (5000) idle ticks counted. A `wake_req` seen while `rwake_en` is low is ignored.
- R7: `drive_k` stays high for exactly HOLD_US (2000) ticks, whatever the line does. It then falls while `suspended` stays high until the resume ends.
- R8: Any non-J line state while suspended leaves the idle state. SE0 with no K before it is a reset: `reset_handoff` pulses and `suspended` falls.
- R9: An enabled `wake_req` that arrives before the idle window is complete is kept pending. It starts the K drive once the window is reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle strobe per microsecond |
| line_state | input | 2 | Decoded upstream line state (00 SE0, 01 J, 10 K, 11 SE1) |
| hs_mode | input | 1 | Link currently operating at high speed |
| rwake_en | input | 1 | Remote wakeup enabled by the host |
| wake_req | input | 1 | Local request to signal remote wakeup |
| suspended | output | 1 | Device is in suspend (including wakeup and resume phases) |
| hs_remembered | output | 1 | Link was at high speed when suspend began |
| drive_k | output | 1 | Drive resume K onto the bus |
| hs_term_en | output | 1 | Enable high-speed terminations |
| fs_pullup_en | output | 1 | Connect the full-speed D+ pull-up |
| reset_handoff | output | 1 | One-cycle pulse: SE0 identified as reset |

## Verification
The bench targets the following corner cases and the failure each would show:
- **K glitch near the idle threshold.** A design that does not restart its idle count would suspend early.
- **High-speed idle that turns out to be a reset.** A design that skips the line sample would suspend on a reset, or miss the reset handoff.
- **Wakeup request that is too early.** It must neither fire at once nor be lost. A request made while wakeup is disabled must not fire later, when wakeup is enabled.
- **Return to high speed after resume.** The termination must come back with `hs_mode` already low. The idle timer must be checked from the end of resume, so a design that kept counting through the resume would revert too soon.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE  = 3'd0,
    ST_REVERT  = 3'd1,
    ST_SUSPEND = 3'd2,
    ST_WAKE    = 3'd3,
    ST_RESUME  = 3'd4
  } susp_st_t;

  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_J   = 2'b01;
  localparam logic [1:0] LS_K   = 2'b10;

  // True when a counter at value cnt, advanced once more, reaches lim.
  function automatic logic last_tick(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) == lim;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return $clog2(max_val + 1) + 1;
  endfunction

endpackage

// File: rtl/susp_tick_ctr.sv
module susp_tick_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (adv && cnt != '1)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/susp_wake_gate.sv
module susp_wake_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic en,
  input  logic req,
  input  logic window_ok,
  output logic go
);
  logic pend;

  assign go = armed && en && (pend || req) && window_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= armed && !go && (pend || (en && req));
  end

  p_pend_needs_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> $past(armed));
endmodule

// File: rtl/usb_susp_ctrl.sv
module usb_susp_ctrl
  import usb_susp_pkg::*;
#(
  parameter int unsigned IDLE_SUSP_US  = 3000,
  parameter int unsigned REVERT_US     = 3060,
  parameter int unsigned SAMPLE_US     = 500,
  parameter int unsigned RWAKE_IDLE_US = 5000,
  parameter int unsigned HOLD_US       = 2000,
  parameter int unsigned EOR_US        = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic [1:0] line_state,
  input  logic       hs_mode,
  input  logic       rwake_en,
  input  logic       wake_req,
  output logic       suspended,
  output logic       hs_remembered,
  output logic       drive_k,
  output logic       hs_term_en,
  output logic       fs_pullup_en,
  output logic       reset_handoff
);
  localparam int unsigned IW = cnt_width(RWAKE_IDLE_US + REVERT_US + 2);
  localparam int unsigned PMAX = (HOLD_US > SAMPLE_US) ? HOLD_US : SAMPLE_US;
  localparam int unsigned PW = cnt_width(PMAX + EOR_US);

  susp_st_t st, st_n;
  logic [IW-1:0] idle_cnt;
  logic [PW-1:0] ph_cnt;
  logic idle_clr, idle_adv, ph_clr, ph_hold;
  logic hs_rem, rem_n, saw_k, sawk_n, ho_q, ho_n;
  logic hs_eff, idle_now, wake_go, wake_armed, window_ok;
  logic is_j, is_k, is_se0;

  assign is_j     = line_state == LS_J;
  assign is_k     = line_state == LS_K;
  assign is_se0   = line_state == LS_SE0;
  assign hs_eff   = hs_mode || hs_rem;
  assign idle_now = hs_eff ? is_se0 : is_j;

  assign wake_armed = (st == ST_SUSPEND) && is_j;
  assign window_ok  = 32'(idle_cnt) >= RWAKE_IDLE_US;

  susp_tick_ctr #(.W(IW)) u_idle (
    .clk(clk), .rst_n(rst_n), .clr(idle_clr), .adv(idle_adv), .cnt(idle_cnt));

  susp_tick_ctr #(.W(PW)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(ph_clr), .adv(us_tick), .cnt(ph_cnt));

  susp_wake_gate u_wake (
    .clk(clk), .rst_n(rst_n), .armed(wake_armed), .en(rwake_en),
    .req(wake_req), .window_ok(window_ok), .go(wake_go));

  always_comb begin
    st_n = st; idle_clr = 1'b0; idle_adv = 1'b0; ph_hold = 1'b0;
    rem_n = hs_rem; sawk_n = saw_k; ho_n = 1'b0;
    case (st)
      ST_ACTIVE: begin
        if (!idle_now) idle_clr = 1'b1;
        else if (us_tick) begin
          idle_adv = 1'b1;
          if (hs_eff && last_tick(32'(idle_cnt), REVERT_US)) st_n = ST_REVERT;
          else if (!hs_eff && 32'(idle_cnt) == IDLE_SUSP_US) begin
            st_n = ST_SUSPEND; rem_n = 1'b0;
          end
        end
      end
      ST_REVERT: begin
        idle_adv = us_tick;
        if (us_tick && last_tick(32'(ph_cnt), SAMPLE_US)) begin
          if (is_j) begin
            st_n = ST_SUSPEND; rem_n = 1'b1;
          end else begin
            st_n = ST_ACTIVE; idle_clr = 1'b1;
            if (is_se0) begin ho_n = 1'b1; rem_n = 1'b0; end
          end
        end
      end
      ST_SUSPEND: begin
        if (!is_j) begin
          st_n = ST_RESUME; sawk_n = is_k;
        end else begin
          idle_adv = us_tick;
          if (wake_go) st_n = ST_WAKE;
        end
      end
      ST_WAKE: begin
        idle_clr = 1'b1;
        if (us_tick && last_tick(32'(ph_cnt), HOLD_US)) begin
          st_n = ST_RESUME; sawk_n = 1'b1;
        end
      end
      ST_RESUME: begin
        idle_clr = 1'b1;
        ph_hold  = !(is_se0 && saw_k);
        if (is_k) sawk_n = 1'b1;
        else if (is_se0) begin
          if (saw_k) begin
            if (us_tick && last_tick(32'(ph_cnt), EOR_US)) begin
              st_n = ST_ACTIVE; sawk_n = 1'b0;
            end
          end else begin
            st_n = ST_ACTIVE; ho_n = 1'b1; rem_n = 1'b0;
          end
        end
      end
      default: st_n = ST_ACTIVE;
    endcase
    ph_clr = (st_n != st) || ph_hold;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_ACTIVE; hs_rem <= 1'b0; saw_k <= 1'b0; ho_q <= 1'b0;
    end else begin
      st <= st_n; hs_rem <= rem_n; saw_k <= sawk_n; ho_q <= ho_n;
    end
  end

  assign suspended     = (st == ST_SUSPEND) || (st == ST_WAKE) || (st == ST_RESUME);
  assign hs_remembered = hs_rem;
  assign drive_k       = st == ST_WAKE;
  assign hs_term_en    = (st == ST_ACTIVE) && hs_eff;
  assign fs_pullup_en  = !hs_term_en;
  assign reset_handoff = ho_q;

  // Checker-only tick count of the K drive length.
  logic [PW-1:0] k_ticks;
  always_ff @(posedge clk) begin
    if (!rst_n || !drive_k) k_ticks <= '0;
    else if (us_tick)       k_ticks <= k_ticks + 1'b1;
  end

  p_suspend_from_j_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> $past(line_state) == LS_J);
  p_handoff_on_se0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reset_handoff |-> $past(line_state) == LS_SE0);
  p_leave_on_se0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(suspended) |-> $past(line_state) == LS_SE0);
  p_wake_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_k) |-> $past(rwake_en) && $past(suspended));
  p_hold_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_k) |-> (32'(k_ticks) == HOLD_US) && suspended);
endmodule

// File: tb/usb_susp_ctrl_bench.sv
module usb_susp_ctrl_bench;
  localparam int SUSP = 3000, REV = 3060, SAMP = 500, RW = 5000, HOLD = 2000, EOR = 2;
  localparam int CAP = 16383;

  logic clk = 0, rst_n = 0, us_tick = 0;
  logic [1:0] line_state = 2'b01;
  logic hs_mode = 0, rwake_en = 0, wake_req = 0;
  logic suspended, hs_remembered, drive_k, hs_term_en, fs_pullup_en, reset_handoff;

  usb_susp_ctrl u_usb_susp_ctrl (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .line_state(line_state),
    .hs_mode(hs_mode), .rwake_en(rwake_en), .wake_req(wake_req),
    .suspended(suspended), .hs_remembered(hs_remembered), .drive_k(drive_k),
    .hs_term_en(hs_term_en), .fs_pullup_en(fs_pullup_en), .reset_handoff(reset_handoff));

  always #10 clk = ~clk;
  always @(negedge clk) us_tick <= ~us_tick;

  int checks = 0, errs = 0, cyc = 0;
  bit saw_ho = 0, done = 0;

  // Behavioural reference: mode 0 awake, 1 reverted, 2 asleep, 3 waking, 4 resuming.
  int m_mode = 0, m_idle = 0, m_ph = 0;
  bit m_rem = 0, m_pend = 0, m_k = 0, m_ho = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int nm; bit hse, idle, go, hold_ph;
    if (!rst_n) begin
      m_mode = 0; m_idle = 0; m_ph = 0; m_rem = 0; m_pend = 0; m_k = 0; m_ho = 0;
    end else begin
      nm = m_mode; m_ho = 0; hold_ph = 0;
      hse = hs_mode || m_rem;
      if (m_mode == 0) begin
        idle = hse ? (line_state == 0) : (line_state == 1);
        if (!idle) m_idle = 0;
        else if (us_tick) begin
          if (hse && m_idle == REV - 1) nm = 1;
          else if (!hse && m_idle == SUSP) begin nm = 2; m_rem = 0; end
          m_idle = (m_idle < CAP) ? m_idle + 1 : CAP;
        end
      end else if (m_mode == 1) begin
        if (us_tick && m_ph == SAMP - 1) begin
          if (line_state == 1) begin nm = 2; m_rem = 1; end
          else begin nm = 0; if (line_state == 0) begin m_ho = 1; m_rem = 0; end end
        end
        if (nm == 0) m_idle = 0; else if (us_tick) m_idle++;
      end else if (m_mode == 2) begin
        if (line_state != 1) begin nm = 4; m_k = (line_state == 2); m_pend = 0; end
        else begin
          go = rwake_en && (m_pend || wake_req) && m_idle >= RW;
          m_pend = !go && (m_pend || (rwake_en && wake_req));
          if (go) nm = 3;
          if (us_tick) m_idle++;
        end
      end else if (m_mode == 3) begin
        m_idle = 0;
        if (us_tick && m_ph == HOLD - 1) begin nm = 4; m_k = 1; end
      end else begin
        m_idle = 0;
        hold_ph = !(line_state == 0 && m_k);
        if (line_state == 2) m_k = 1;
        else if (line_state == 0) begin
          if (m_k) begin
            if (us_tick && m_ph == EOR - 1) begin nm = 0; m_k = 0; end
          end else begin nm = 0; m_ho = 1; m_rem = 0; end
        end
      end
      if (nm != m_mode || hold_ph) m_ph = 0; else if (us_tick) m_ph++;
      m_mode = nm;
    end
    #5;
    if (rst_n && !done) begin
      bit e_s, e_t;
      e_s = m_mode >= 2;
      e_t = (m_mode == 0) && (hs_mode || m_rem);
      if (reset_handoff) saw_ho = 1;
      checks++;
      if (suspended !== e_s) begin errs++; $display("FAIL R1 suspended act=%0d exp=%0d t=%0t", suspended, e_s, $time); end
      else if (hs_remembered !== m_rem) begin errs++; $display("FAIL R4 remembered act=%0d exp=%0d t=%0t", hs_remembered, m_rem, $time); end
      else if (drive_k !== (m_mode == 3)) begin errs++; $display("FAIL R6 drive_k act=%0d exp=%0d t=%0t", drive_k, m_mode == 3, $time); end
      else if (hs_term_en !== e_t || fs_pullup_en !== !e_t) begin errs++; $display("FAIL R2 term act=%0d exp=%0d t=%0t", hs_term_en, e_t, $time); end
      else if (reset_handoff !== m_ho) begin errs++; $display("FAIL R3 handoff act=%0d exp=%0d t=%0t", reset_handoff, m_ho, $time); end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1; errs++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  task automatic ticks(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!suspended && !drive_k && fs_pullup_en && !hs_term_en && !reset_handoff, "R1 reset state", suspended, 0);

    // R1: K glitch restarts the full-speed idle count
    ticks(2000);
    line_state = 2'b10; repeat (5) @(negedge clk); line_state = 2'b01;
    ticks(2990); chk(!suspended, "R1 not yet suspended", suspended, 0);
    ticks(20);   chk(suspended,  "R1 suspended", suspended, 1);

    // R6: request while disabled is ignored
    wake_req = 1; @(negedge clk); wake_req = 0;
    ticks(100); chk(!drive_k, "R6 disabled request ignored", drive_k, 0);
    // R9: early enabled request is held
    rwake_en = 1; wake_req = 1; @(negedge clk); wake_req = 0;
    ticks(100);  chk(!drive_k, "R9 early request held", drive_k, 0);
    ticks(1800); chk(drive_k,  "R9 pending request fires", drive_k, 1);
    line_state = 2'b10;
    ticks(1000); chk(drive_k, "R7 K still held", drive_k, 1);
    ticks(1000); chk(!drive_k && suspended, "R7 K released, still suspended", drive_k, 0);
    ticks(500);
    line_state = 2'b00; @(negedge clk);
    chk(suspended, "R5 end of resume not immediate", suspended, 1);
    ticks(3); chk(!suspended && fs_pullup_en, "R5 awake at full speed", suspended, 0);
    line_state = 2'b01; rwake_en = 0;

    // R2/R3/R4: high-speed idle, revert, sample J
    hs_mode = 1; line_state = 2'b00;
    ticks(3000); chk(hs_term_en, "R2 no early reversion", hs_term_en, 1);
    ticks(100);  chk(!hs_term_en && fs_pullup_en, "R2 reverted", hs_term_en, 0);
    line_state = 2'b01;
    ticks(400); chk(!suspended, "R3 before sample", suspended, 0);
    ticks(100); chk(suspended && hs_remembered, "R3 J sample suspends, R4 remembers", hs_remembered, 1);
    hs_mode = 0;
    line_state = 2'b10; ticks(1000);
    chk(suspended, "R8 resume in progress", suspended, 1);
    line_state = 2'b00; ticks(3);
    chk(!suspended && hs_term_en, "R4 back to high speed", hs_term_en, 1);
    chk(!saw_ho, "R4 no reset handoff", saw_ho, 0);
    ticks(3037); chk(hs_term_en, "R5 idle restarted at resume end", hs_term_en, 1);
    ticks(40);   chk(!hs_term_en, "R5 reversion after restart", hs_term_en, 0);
    ticks(500);
    chk(saw_ho && !hs_remembered && !suspended, "R3 SE0 sample hands off", saw_ho, 1);
    line_state = 2'b01; saw_ho = 0;

    // R8: reset straight from suspend
    ticks(3010); chk(suspended, "R8 suspended again", suspended, 1);
    line_state = 2'b00; ticks(2);
    chk(saw_ho && !suspended, "R8 SE0 from suspend is reset", saw_ho, 1);
    line_state = 2'b01; ticks(5);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule